// File: doc/BRIEF.md
# Approximate Split Adder-Subtractor

This block adds or subtracts two unsigned 16-bit words while trading accuracy in the low byte for a short carry path. The eight least significant positions are built from multiplexer-steered approximate cells. Each of those cells derives its outgoing carry from its own two operand bits only. It then selects its sum bit through a 2:1 multiplexer that this local carry controls. Carries therefore never travel through the low byte. The upper byte is an exact ripple-carry chain. Its carry input is the approximate carry leaving the top low cell.

Subtraction reuses the same datapath. The second operand is complemented, and a 1 is offered as the carry into bit 0. A parameter chooses between two cell flavours. The first flavour falls back to the local carry when it is set. The second flavour falls back to the incoming carry. Another parameter adds one register stage on the result. The block is meant for error-tolerant arithmetic such as rotation stages in transform engines, where a bounded low-order error is acceptable.

Top module: `mux_addsub`

## Requirements
- R1: With the output register enabled (default), `sum_o` and `cout_o` are 0 while `rst_n` is low, and they show the result for the inputs sampled at a rising edge from just after that edge onward (one cycle of latency).
- R2: The carry leaving low cell i is `a[i] & e[i]`, where e is the effective second operand (`op_b_i`, or `~op_b_i` when `sub_i` is 1). The carry entering a cell never reaches its outgoing carry, so low-byte carries do not ripple.
- R3: Cell flavour 0 (`CELL_OR_SEL`): bit i of the low byte (i = 0..7) equals `a[i] | e[i]`. This is the local carry when that carry is 1, and `a[i] ^ e[i]` otherwise.
- R4: Cell flavour 1 (`CELL_CIN_SEL`): bit i of the low byte equals the incoming carry when `a[i] & e[i]` is 1, and `a[i] ^ e[i] ^ cin_i` otherwise. Here `cin_0 = sub_i` and `cin_i = a[i-1] & e[i-1]`.
- R5: Bits 15:8 of `sum_o` and `cout_o` together equal the exact 9-bit sum `a[15:8] + e[15:8] + (a[7] & e[7])`.
- R6: When `sub_i` is 1, the second operand is bitwise inverted and a carry of 1 is injected at bit 0. That carry is seen only by flavour 1, in its bit 0 cell.
- R7: For flavour 0, the 17-bit value `{cout_o, sum_o}` differs from the exact 17-bit result `a + e + sub_i` by at most 255 in absolute value.
- R8: A carry generated in the low byte does not propagate within it. For example, with flavour 0, `0x00FF + 0x0001` gives `0x00FF` and `cout_o` = 0. With flavour 1 the same sum gives `0x00FC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| op_a_i | input | 16 | First operand |
| op_b_i | input | 16 | Second operand |
| sub_i | input | 1 | 1 selects subtraction (op_a_i - op_b_i), 0 selects addition |
| sum_o | output | 16 | Approximate result |
| cout_o | output | 1 | Carry out of the exact upper byte |

## Verification
The most telling situation is an operand pair where the exact carry into bit 8 is 1 but the approximate carry from bit 7 is 0. This happens when a long carry would ripple through the low byte while bits 7 of the operands differ. Here the approximate result is furthest from the true value. For flavour 1 the low byte can then even collapse toward zero. Directed pairs such as `0x00FF + 0x0001` and `0x00C0 + 0x0040` force this case in both directions of the flavour choice. A long stream of random operands, with random add and subtract selection, then runs both flavours side by side against a bit-level reference and the flavour 0 error bound.

// File: rtl/mux_addsub_pkg.sv
package mux_addsub_pkg;

  // Low-byte approximate cell flavour.
  typedef enum logic {
    CELL_OR_SEL  = 1'b0,  // sum falls back to the local carry
    CELL_CIN_SEL = 1'b1   // sum falls back to the incoming carry
  } cell_kind_e;

endpackage

// File: rtl/mxa_cell.sv
module mxa_cell
  import mux_addsub_pkg::*;
#(
  parameter cell_kind_e KIND = CELL_OR_SEL
) (
  input  logic a_i,
  input  logic b_i,
  input  logic cin_i,
  output logic sum_o,
  output logic cout_o
);

  logic gen_c;
  logic half_s;

  // Local carry: only the two operand bits take part.
  assign gen_c  = a_i & b_i;
  assign half_s = a_i ^ b_i;
  assign cout_o = gen_c;

  generate
    if (KIND == CELL_OR_SEL) begin : g_or_sel
      logic unused_cin;
      assign unused_cin = cin_i;
      always_comb begin
        if (gen_c) sum_o = gen_c;
        else       sum_o = half_s;
      end
    end else begin : g_cin_sel
      always_comb begin
        if (gen_c) sum_o = cin_i;
        else       sum_o = half_s ^ cin_i;
      end
    end
  endgenerate

endmodule

// File: rtl/mxa_low_part.sv
module mxa_low_part
  import mux_addsub_pkg::*;
#(
  parameter int         BITS = 8,
  parameter cell_kind_e KIND = CELL_OR_SEL
) (
  input  logic [BITS-1:0] a_i,
  input  logic [BITS-1:0] b_i,
  input  logic            cin_i,
  output logic [BITS-1:0] sum_o,
  output logic            cout_o
);

  logic [BITS:0] cy;

  assign cy[0] = cin_i;

  generate
    for (genvar i = 0; i < BITS; i++) begin : g_cell
      mxa_cell #(.KIND(KIND)) cell_i (
        .a_i   (a_i[i]),
        .b_i   (b_i[i]),
        .cin_i (cy[i]),
        .sum_o (sum_o[i]),
        .cout_o(cy[i+1])
      );

      // R2: carry leaving a cell depends on its operand bits only
      always_comb begin
        p_local_carry_r2: assert (cy[i+1] == (a_i[i] & b_i[i]));
      end

      if (KIND == CELL_OR_SEL) begin : g_chk_or
        // R3: flavour 0 sum equals OR of the operand bits
        always_comb begin
          p_or_sum_r3: assert (sum_o[i] == (a_i[i] | b_i[i]));
        end
      end else begin : g_chk_cin
        // R4: flavour 1 passes the incoming carry when a carry is generated
        always_comb begin
          if (a_i[i] & b_i[i]) begin
            p_cin_pass_r4: assert (sum_o[i] == cy[i]);
          end
        end
      end
    end
  endgenerate

  assign cout_o = cy[BITS];

endmodule

// File: rtl/mxa_exact_part.sv
module mxa_exact_part #(
  parameter int BITS = 8
) (
  input  logic [BITS-1:0] a_i,
  input  logic [BITS-1:0] b_i,
  input  logic            cin_i,
  output logic [BITS-1:0] sum_o,
  output logic            cout_o
);

  logic [BITS:0]   cy;
  logic [BITS-1:0] prop;

  assign cy[0] = cin_i;

  generate
    for (genvar i = 0; i < BITS; i++) begin : g_fa
      assign prop[i]  = a_i[i] ^ b_i[i];
      assign sum_o[i] = prop[i] ^ cy[i];
      assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & prop[i]);
    end
  endgenerate

  assign cout_o = cy[BITS];

  // R5: ripple chain agrees with arithmetic addition
  always_comb begin
    p_exact_sum_r5: assert ({cout_o, sum_o} ==
      ({1'b0, a_i} + {1'b0, b_i} + {{BITS{1'b0}}, cin_i}));
  end

endmodule

// File: rtl/mux_addsub.sv
module mux_addsub
  import mux_addsub_pkg::*;
#(
  parameter int         WIDTH   = 16,
  parameter int         LO_BITS = 8,
  parameter cell_kind_e KIND    = CELL_OR_SEL,
  parameter bit         REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int HI_BITS = WIDTH - LO_BITS;

  logic [WIDTH-1:0]   b_eff;
  logic [LO_BITS-1:0] lo_sum;
  logic               lo_cout;
  logic [HI_BITS-1:0] hi_sum;
  logic               hi_cout;
  logic [WIDTH-1:0]   res_d;
  logic               cout_d;

  // R6: subtraction through operand inversion and carry injection
  assign b_eff = sub_i ? ~op_b_i : op_b_i;

  mxa_low_part #(.BITS(LO_BITS), .KIND(KIND)) low_i (
    .a_i   (op_a_i[LO_BITS-1:0]),
    .b_i   (b_eff[LO_BITS-1:0]),
    .cin_i (sub_i),
    .sum_o (lo_sum),
    .cout_o(lo_cout)
  );

  mxa_exact_part #(.BITS(HI_BITS)) high_i (
    .a_i   (op_a_i[WIDTH-1:LO_BITS]),
    .b_i   (b_eff[WIDTH-1:LO_BITS]),
    .cin_i (lo_cout),
    .sum_o (hi_sum),
    .cout_o(hi_cout)
  );

  // R5: carry into the exact byte comes from the top low cell alone
  always_comb begin
    p_hi_link_r5: assert (lo_cout ==
      (op_a_i[LO_BITS-1] & b_eff[LO_BITS-1]));
  end

  // Next-state values
  always_comb begin
    res_d  = {hi_sum, lo_sum};
    cout_d = hi_cout;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [WIDTH-1:0] res_q;
      logic             cout_q;
      logic             primed_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q  <= '0;
          cout_q <= 1'b0;
        end else begin
          res_q  <= res_d;
          cout_q <= cout_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
      end

      assign sum_o  = res_q;
      assign cout_o = cout_q;

      // R1: steady inputs give a steady registered result
      p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $stable(op_a_i) && $stable(op_b_i) && $stable(sub_i))
        |=> ($stable(sum_o) && $stable(cout_o)));

      // R1: result register is cleared while reset is held
      always_comb begin
        if (!rst_n) begin
          p_reset_zero_r1: assert (res_q == '0 && cout_q == 1'b0);
        end
      end
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign sum_o  = res_d;
      assign cout_o = cout_d;
    end
  endgenerate

endmodule

// File: tb/mux_addsub_tb_top.sv
module mux_addsub_tb_top;
  import mux_addsub_pkg::*;

  localparam int W = 16;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         s;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = 16'h1234;
  logic [W-1:0] op_b = 16'h4321;
  logic         sub = 1'b1;
  logic [W-1:0] sum1, sum2;
  logic         cout1, cout2;

  int     n_checks = 0;
  int     n_fail = 0;
  bit     done = 1'b0;
  item_t  sb_q[$];

  always #2 clk = ~clk;  // 250 MHz

  mux_addsub #(.KIND(CELL_OR_SEL)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b),
    .sub_i(sub), .sum_o(sum1), .cout_o(cout1)
  );

  mux_addsub #(.KIND(CELL_CIN_SEL)) dut_ii (
    .clk(clk), .rst_n(rst_n), .op_a_i(op_a), .op_b_i(op_b),
    .sub_i(sub), .sum_o(sum2), .cout_o(cout2)
  );

  // Reference built from R2..R6
  function automatic logic [W:0] ref_val(input logic [W-1:0] a,
                                         input logic [W-1:0] b,
                                         input logic s, input bit v2);
    logic [W-1:0] e;
    logic [7:0]   lo;
    logic         c;
    logic         g;
    logic [8:0]   hi;
    e = s ? ~b : b;
    c = s;
    for (int i = 0; i < 8; i++) begin
      g = a[i] & e[i];
      if (!v2) lo[i] = a[i] | e[i];
      else     lo[i] = g ? c : (a[i] ^ e[i] ^ c);
      c = g;
    end
    hi = {1'b0, a[15:8]} + {1'b0, e[15:8]} + {8'd0, c};
    return {hi, lo};
  endfunction

  task automatic check(input string req, input logic [W:0] act,
                       input logic [W:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input string tag);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; sub = s;
    it.a = a; it.b = b; it.s = s; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: result captured at this edge belongs to the oldest item
  always @(posedge clk) begin
    #1;
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      logic [W-1:0] e;
      logic [8:0]   hi_exp;
      logic [W:0]   exact;
      int           diff;
      it = sb_q.pop_front();
      e  = it.s ? ~it.b : it.b;
      check({it.tag, " flavour0"}, {cout1, sum1}, ref_val(it.a, it.b, it.s, 1'b0));
      check({it.tag, " flavour1"}, {cout2, sum2}, ref_val(it.a, it.b, it.s, 1'b1));
      // R5: upper byte exact given the approximate carry
      hi_exp = {1'b0, it.a[15:8]} + {1'b0, e[15:8]} + {8'd0, it.a[7] & e[7]};
      check("R5 upper byte", {8'd0, cout1, sum1[15:8]}, {8'd0, hi_exp});
      // R7: error bound for flavour 0
      exact = {1'b0, it.a} + {1'b0, e} + {{W{1'b0}}, it.s};
      diff  = int'({cout1, sum1}) - int'(exact);
      if (diff < 0) diff = -diff;
      n_checks++;
      if (diff > 255) begin
        n_fail++;
        $display("FAIL R7: actual error %0d expected <= 255", diff);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: outputs cleared under reset despite live inputs
    #11;
    check("R1 reset flavour0", {cout1, sum1}, 17'd0);
    check("R1 reset flavour1", {cout2, sum2}, 17'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: no ripple in low byte, literal expectations
    drive(16'h00FF, 16'h0001, 1'b0, "R8 no-ripple");
    @(posedge clk); #1;
    check("R8 flavour0 literal", {cout1, sum1}, {1'b0, 16'h00FF});
    check("R8 flavour1 literal", {cout2, sum2}, {1'b0, 16'h00FC});

    // R2: carry from bit 7 feeds the upper byte
    drive(16'h0080, 16'h0080, 1'b0, "R2 bit7 carry");
    @(posedge clk); #1;
    check("R2 flavour0 literal", {cout1, sum1}, {1'b0, 16'h0180});
    // R4: flavour 1 collapses when carry should have rippled
    drive(16'h00C0, 16'h0040, 1'b0, "R4 collapse");
    @(posedge clk); #1;
    check("R4 flavour1 literal", {cout2, sum2}, {1'b0, 16'h0000});
    // R6: subtraction, injected carry only seen by flavour 1 bit 0
    drive(16'h0001, 16'h0001, 1'b1, "R6 sub equal");
    @(posedge clk); #1;
    check("R6 flavour0 literal", {cout1, sum1}, {1'b0, 16'hFFFF});
    check("R6 flavour1 literal", {cout2, sum2}, ref_val(16'h0001, 16'h0001, 1'b1, 1'b1));

    // R3 R4 R5 R6: pattern sweep
    drive(16'hFFFF, 16'hFFFF, 1'b0, "R5 all ones add");
    drive(16'hFFFF, 16'h0001, 1'b0, "R5 carry out");
    drive(16'hAAAA, 16'h5555, 1'b0, "R3 alternating");
    drive(16'h5555, 16'h5555, 1'b1, "R6 sub self");
    drive(16'h8000, 16'h7FFF, 1'b1, "R6 sub boundary");
    drive(16'h0000, 16'h0000, 1'b0, "R3 zero");
    drive(16'h0000, 16'h0000, 1'b1, "R6 zero minus zero");

    // R1: back-to-back changing inputs exercise one-cycle latency
    for (int k = 0; k < 3000; k++) begin
      drive(W'($urandom), W'($urandom), 1'($urandom), "R1 R4 R7 random");
    end

    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule